// File: doc/BRIEF.md
# Supervisor Reset and Bus-Activity Watchdog

This block drives a system reset from two independent sources. The first is a digital supply-good flag from an external voltage monitor. Whenever that flag is low, reset is held. After the flag returns, reset is kept asserted for a fixed recovery delay. The second source is a watchdog that watches the two-wire serial bus. A start condition on the bus restarts the watchdog, where a start condition means SDA falling while SCL is high. If no start condition arrives within the selected period, the watchdog forces a reset of the same recovery length.

All delays are measured in ticks of a slow timebase enable, `tick_en`. The recovery delay and the three watchdog periods are tick counts set by parameters. Their nominal values are 250 ms for the recovery delay and 1.4 s, 600 ms and 200 ms for the periods, with one tick per millisecond. A 2-bit code picks the watchdog period, and one code value turns the watchdog off.

Reset is presented in both polarities. A third output, `bus_abort`, tells the serial interface to drop any transfer in progress and to refuse new transfers while reset is active. It acts at the transfer level only. A nonvolatile write that is already running is not stopped by it, so the interface keeps its write-busy state until that write ends.

Top module: `sup_rst_wdog`

## Requirements
- R1: While `supply_ok` is low at a clock edge, reset is asserted from that edge on, and ticks do not release it.
- R2: Reset releases on the HOLD_TICKS-th `tick_en` edge counted after `supply_ok` is high. Release happens only on a tick edge.
- R3: A start condition (SDA falling while SCL is high, both seen through two-flop synchronizers) restarts the watchdog count from zero. An SDA change while SCL is low does not restart it.
- R4: Without a restart, the watchdog fires on the N-th tick after its last reload, where N is the selected period. Reset then asserts at once and is held for HOLD_TICKS further ticks.
- R5: Period code 2'b00 selects LONG_TICKS, 2'b01 selects MID_TICKS and 2'b10 selects SHORT_TICKS. Code 2'b11 turns the watchdog off, so it never causes a reset.
- R6: `bus_abort` is high exactly when reset is active.
- R7: `rst_out` and `rst_out_n` are always complementary.
- R8: The watchdog count is held at zero while reset is active, and counting starts again from zero after release.
- R9: Any change of the period code reloads the watchdog count to zero, so the new period runs in full from the change.
- R10: A low `rst_n` at a clock edge puts the block into reset-active, with the recovery and watchdog counts cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable from the slow timebase |
| supply_ok | input | 1 | Digital supply-good flag, synchronous to clk |
| bus_scl | input | 1 | Serial bus clock line (asynchronous) |
| bus_sda | input | 1 | Serial bus data line (asynchronous) |
| wd_code | input | 2 | Watchdog period select; 2'b11 means off |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |
| bus_abort | output | 1 | Ends and refuses serial transfers while reset is active |

## Verification
The bench checks each watchdog period one tick short of expiry and exactly at expiry. A design off by one in its limit compare would release or fire one tick early or late. The bench also places a data-phase SDA edge (SCL low) between two start conditions. A detector that treats every SDA fall as a restart would then push the expiry back and miss the expected reset. Two further cases target the counter: a period-code change partway through a long period, and a watchdog reset followed by a full fresh period. A design that does not reload on the code change, or does not clear the count during reset, fires early in these cases. Finally, the bench holds `supply_ok` low for many ticks. A recovery counter that keeps running while the supply is bad would release too soon after the supply returns.

// File: rtl/sup_wd_pkg.sv
// Package: shared types for the supervisor reset and watchdog block.
// Assumes: the period code is a 2-bit field decoded only by the watchdog timer.
package sup_wd_pkg;
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_code_e;
endpackage

// File: rtl/sup_sync2.sv
// Module: two-flop synchronizer for a vector of asynchronous bus lines.
// Assumes: each bit is sampled on its own; the bits are not treated as one coherent group.
module sup_sync2 #(
    parameter int          W    = 2,
    parameter logic [W-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] meta;

    // Two register stages with a reset value equal to the idle bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= INIT;
            q_out <= INIT;
        end else begin
            meta  <= d_in;
            q_out <= meta;
        end
    end
endmodule

// File: rtl/sup_start_det.sv
// Module: finds a start condition (SDA falling while SCL stays high) on synchronized lines.
// Assumes: the inputs are already synchronized to clk; gives a one-cycle kick pulse.
module sup_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic kick
);
    logic scl_d, sda_d;

    // Keep the previous line levels so the detector can see edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // SCL high on both samples and SDA going from high to low.
    always_comb kick = scl_d & scl_s & sda_d & ~sda_s;
endmodule

// File: rtl/sup_rst_seq.sv
// Module: reset sequencer; holds reset while supply is bad or on a watchdog fire,
// then releases after HOLD_TICKS timebase ticks.
// Assumes: supply_ok is synchronous to clk; bite is a one-cycle request.
module sup_rst_seq #(
    parameter int HOLD_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic bite,
    output logic active
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    logic [HW-1:0] hold_cnt;

    // Restart the recovery delay on any cause, and count it down on ticks while the supply is good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b1;
            hold_cnt <= '0;
        end else if (!supply_ok || bite) begin
            active   <= 1'b1;
            hold_cnt <= '0;
        end else if (active && tick) begin
            if (hold_cnt == HOLD_LAST) begin
                active   <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_wd_timer.sv
// Module: watchdog counter with a code-selected period; fires a one-cycle bite on expiry.
// Assumes: hold is high while reset is active; kick and a code change both reload the count.
module sup_wd_timer
    import sup_wd_pkg::*;
#(
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200,
    localparam int MAXP = (LONG_TICKS > MID_TICKS)
                          ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                          : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS),
    localparam int CW   = $clog2(MAXP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic          kick,
    input  logic [1:0]    code,
    output logic          bite,
    output logic [CW-1:0] cnt
);
    wd_code_e      code_e, code_q;
    logic [CW-1:0] last;
    logic          enabled, reload;

    // Decode the period code into the last count value before expiry.
    always_comb begin
        code_e  = wd_code_e'(code);
        enabled = 1'b1;
        case (code_e)
            WD_LONG:  last = CW'(LONG_TICKS - 1);
            WD_MID:   last = CW'(MID_TICKS - 1);
            WD_SHORT: last = CW'(SHORT_TICKS - 1);
            default: begin
                last    = '0;
                enabled = 1'b0;
            end
        endcase
        reload = (code_e != code_q);
        bite   = !hold && enabled && tick && !kick && !reload && (cnt == last);
    end

    // Clear on hold, kick, code change or expiry; otherwise advance on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            code_q <= WD_OFF;
        end else begin
            code_q <= code_e;
            if (hold || kick || reload || bite)
                cnt <= '0;
            else if (enabled && tick)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_rst_wdog.sv
// Module: top of the supervisor; combines the supply-good reset with a bus-activity watchdog.
// Assumes: tick_en is a one-cycle pulse from a slow timebase; the bus lines are asynchronous.
module sup_rst_wdog #(
    parameter int HOLD_TICKS  = 250,
    parameter int LONG_TICKS  = 1400,
    parameter int MID_TICKS   = 600,
    parameter int SHORT_TICKS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       supply_ok,
    input  logic       bus_scl,
    input  logic       bus_sda,
    input  logic [1:0] wd_code,
    output logic       rst_out_n,
    output logic       rst_out,
    output logic       bus_abort
);
    localparam int MAXP = (LONG_TICKS > MID_TICKS)
                          ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                          : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
    localparam int CW = $clog2(MAXP + 1);

    logic [1:0]    bus_s;
    logic          kick, bite, rst_active;
    logic [CW-1:0] wd_cnt;

    sup_sync2 #(.W(2), .INIT(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({bus_scl, bus_sda}),
        .q_out (bus_s)
    );

    sup_start_det u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (bus_s[1]),
        .sda_s (bus_s[0]),
        .kick  (kick)
    );

    sup_wd_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .MID_TICKS   (MID_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_wd (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .hold  (rst_active),
        .kick  (kick),
        .code  (wd_code),
        .bite  (bite),
        .cnt   (wd_cnt)
    );

    sup_rst_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_en),
        .supply_ok (supply_ok),
        .bite      (bite),
        .active    (rst_active)
    );

    // Drive both reset polarities and the bus abort from the one registered state.
    always_comb begin
        rst_out   = rst_active;
        rst_out_n = ~rst_active;
        bus_abort = rst_active;
    end
endmodule

// File: rtl/sup_rst_wdog_chk.sv
// Module: assertion checker bound to the supervisor top.
// Assumes: it only observes; all properties are disabled while rst_n is low.
module sup_rst_wdog_chk #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          supply_ok,
    input logic [1:0]    wd_code,
    input logic          rst_out,
    input logic          rst_out_n,
    input logic          bus_abort,
    input logic          kick,
    input logic          rst_active,
    input logic [CW-1:0] wd_cnt
);
    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_out);

    assert_release_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(tick_en) && $past(supply_ok)));

    assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (wd_cnt == '0));

    assert_off_no_rst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_code == 2'b11 && supply_ok) |=> !$rose(rst_out));

    assert_abort_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort == rst_out);

    assert_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out != rst_out_n);

    assert_held_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> (wd_cnt == '0));

    assert_code_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_code != $past(wd_code)) |=> (wd_cnt == '0));
endmodule

bind sup_rst_wdog sup_rst_wdog_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .supply_ok  (supply_ok),
    .wd_code    (wd_code),
    .rst_out    (rst_out),
    .rst_out_n  (rst_out_n),
    .bus_abort  (bus_abort),
    .kick       (kick),
    .rst_active (rst_active),
    .wd_cnt     (wd_cnt)
);

// File: tb/sim_sup_rst_wdog.sv
// Bench: directed corner cases plus seeded random kick timing, against tick-count expectations.
module sim_sup_rst_wdog;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 5;
    localparam int LONGP = 12;
    localparam int MIDP  = 7;
    localparam int SHRTP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       supply_ok = 1'b0;
    logic       bus_scl = 1'b1;
    logic       bus_sda = 1'b1;
    logic [1:0] wd_code = 2'b11;
    logic       rst_out_n, rst_out, bus_abort;

    int n_chk = 0;
    int n_bad = 0;
    int since = 0;
    logic done = 1'b0;

    sup_rst_wdog #(
        .HOLD_TICKS (HOLD),
        .LONG_TICKS (LONGP),
        .MID_TICKS  (MIDP),
        .SHORT_TICKS(SHRTP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .supply_ok(supply_ok),
        .bus_scl(bus_scl), .bus_sda(bus_sda), .wd_code(wd_code),
        .rst_out_n(rst_out_n), .rst_out(rst_out), .bus_abort(bus_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Period in ticks for a code, 0 meaning the watchdog is off (R5 mapping).
    function automatic int lim_of(input logic [1:0] c);
        case (c)
            2'b00:   return LONGP;
            2'b01:   return MIDP;
            2'b10:   return SHRTP;
            default: return 0;
        endcase
    endfunction

    task automatic check(input logic exp_rst, input string req);
        n_chk++;
        if (rst_out !== exp_rst || rst_out_n !== ~exp_rst || bus_abort !== exp_rst) begin
            n_bad++;
            $display("FAIL %s: rst=%b rst_n=%b abort=%b expected rst=%b",
                     req, rst_out, rst_out_n, bus_abort, exp_rst);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_cond();
        bus_sda = 1'b1; idle(3);
        bus_scl = 1'b1; idle(3);
        bus_sda = 1'b0; idle(3);
        bus_scl = 1'b0; idle(4);
    endtask

    task automatic data_edge();
        bus_scl = 1'b0; idle(2);
        bus_sda = 1'b1; idle(3);
        bus_sda = 1'b0; idle(4);
    endtask

    task automatic set_code(input logic [1:0] c);
        @(negedge clk) wd_code = c;
        idle(2);
    endtask

    // Run HOLD ticks after a reset cause and expect release on the last one (R2).
    task automatic expect_release(input string req);
        for (int i = 0; i < HOLD - 1; i++) tick1();
        check(1'b1, req);
        tick1();
        check(1'b0, req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int dummy;
        dummy = $urandom(32'd1234);
        idle(3);
        check(1'b1, "R10 reset state");
        rst_n = 1'b1;
        // R1: supply low holds reset across many ticks.
        for (int i = 0; i < 2 * HOLD; i++) tick1();
        check(1'b1, "R1 supply low");
        supply_ok = 1'b1;
        idle(2);
        expect_release("R2 power-up hold");
        // R5: code off never fires.
        for (int i = 0; i < 3 * LONGP; i++) tick1();
        check(1'b0, "R5 code 11 off");

        // R4/R5: each period, one short of expiry and at expiry; R8 fresh period after.
        for (int c = 0; c < 3; c++) begin
            set_code(2'(c));
            for (int i = 0; i < lim_of(2'(c)) - 1; i++) tick1();
            check(1'b0, "R4 before expiry");
            tick1();
            check(1'b1, "R4 R5 expiry");
            expect_release("R4 watchdog hold");
            for (int i = 0; i < lim_of(2'(c)) - 1; i++) tick1();
            check(1'b0, "R8 fresh period after reset");
            tick1();
            check(1'b1, "R8 expiry after fresh period");
            expect_release("R4 watchdog hold again");
            set_code(2'b11);
        end

        // R3: start restarts, data edge does not.
        set_code(2'b10);
        tick1(); tick1(); tick1();
        start_cond();
        tick1(); tick1();
        data_edge();
        tick1();
        check(1'b0, "R3 start restarted count");
        tick1();
        check(1'b1, "R3 data edge ignored");
        expect_release("R3 hold");

        // R9: code change partway reloads.
        set_code(2'b00);
        tick1(); tick1(); tick1();
        set_code(2'b10);
        for (int i = 0; i < SHRTP - 1; i++) tick1();
        check(1'b0, "R9 reload on code change");
        tick1();
        check(1'b1, "R9 full new period");
        expect_release("R9 hold");

        // R1: supply drop while running asserts on the next edge.
        set_code(2'b11);
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk);
        check(1'b1, "R1 supply drop");
        for (int i = 0; i < 2 * HOLD; i++) tick1();
        check(1'b1, "R1 ticks ignored while low");
        supply_ok = 1'b1;
        idle(1);
        expect_release("R2 brownout hold");

        // Random: random codes and kick spacing against the tick-count model.
        since = 0;
        for (int it = 0; it < 60; it++) begin
            logic [1:0] nc;
            int lim, n;
            nc = 2'($urandom_range(0, 3));
            if (nc != wd_code) since = 0;
            set_code(nc);
            lim = lim_of(nc);
            n = $urandom_range(1, (lim == 0) ? 6 : lim + 1);
            for (int k = 0; k < n; k++) begin
                tick1();
                since++;
                if (lim != 0 && since >= lim) begin
                    check(1'b1, "R4 random expiry");
                    expect_release("R2 random hold");
                    since = 0;
                    break;
                end
                check(1'b0, "R3 random no expiry");
            end
            start_cond();
            since = 0;
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule